// File: doc/BRIEF.md
# LED Blink and Dimming Driver

This block drives a single LED pin. Software sets it up through a small byte-wide register port with three registers: a control byte, an effect byte and a brightness level. In steady mode the pin carries a pulse-width signal whose duty cycle follows the 8-bit level. In blink mode the same pulse-width signal is switched on and off at one of four power-of-two rates, with equal on and off halves.

An ownership bit in the control byte decides who drives the pin. When software owns it, the register settings apply. When software does not own it, the pin copies an external hardware status input, such as a charge indicator. A parameter sets how many system clocks make up one quarter-second tick. That tick clocks a small phase counter, and the blink rates are taken from its bits.

Top module: `led_blink_pwm`

## Requirements
- R1: After a synchronous reset, `led_out` is 0. Reading back gives control 0x08 (current code 2, everything else clear), effect 0x02 (steady) and level 0x00.
- R2: Address 0 is control, 1 is effect and 2 is level. A write stores the full byte on the next edge. `rd_data` is registered and shows, one cycle after an address is presented, the byte held at that address. Address 3 reads 0x00 and writes to it are dropped.
- R3: With control bit 0 (software owns) set and control bit 1 (enable) clear, `led_out` is 0 whatever the level and effect are.
- R4: In software-owned, enabled, steady mode, `led_out` is high in exactly those cycles where a free-running 8-bit counter (0 after reset) is below the level. Level 0 keeps the pin low, and level 255 gives 255 high cycles in every 256.
- R5: Control bits [5:4] select the blink rate: 00 is 0.25 Hz, 01 is 0.5 Hz, 10 is 1 Hz and 11 is 2 Hz.
- R6: Effect bit 2 set selects blinking. Otherwise the mode is steady, including when only bit 3 (reserved breathing) or no bit is set.
- R7: In blink mode the pulse-width signal is passed for half of each blink period and blocked for the other half. With T = TICK_CLKS, the half-period is T*2^(3-code) clocks (8T, 4T, 2T or T).
- R8: With control bit 0 clear, `led_out` equals `hw_status` from one cycle earlier.
- R9: A write that changes the rate field, or that changes the blink/steady decode of the effect byte, restarts the blink phase at the start of an on half.
- R10: Control bits [3:2] (current-limit code) and [7:6] are stored and read back but do not affect `led_out` or the blink phase.
- R11: `led_out` is registered: it reflects the registers, counters and `hw_status` as they were before the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| hw_status | input | 1 | External status that drives the LED when software does not own it |
| led_out | output | 1 | LED drive, registered |

## Verification
The bench builds the block with TICK_CLKS set to 4. With that value the slowest blink period is 64 clocks, so all four rates, several full periods of each, and restarts in mid-period fit in a few thousand cycles. The level is kept at its full 8-bit width, so duty counts over one 256-cycle window can be checked exactly for levels 0, 1, 128 and 255.

// File: rtl/led_pkg.sv
package led_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_EFFECT = 2'd1,
    ADDR_LEVEL  = 2'd2,
    ADDR_NONE   = 2'd3
  } led_addr_e;

  localparam int CTRL_OWN_BIT   = 0;
  localparam int CTRL_EN_BIT    = 1;
  localparam int CTRL_RATE_LO   = 4;
  localparam int EFF_BLINK_BIT  = 2;

  localparam logic [DW-1:0] CTRL_RESET = 8'h08;
  localparam logic [DW-1:0] EFF_RESET  = 8'h02;
endpackage

// File: rtl/led_regs.sv
module led_regs
  import led_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          sw_own,
  output logic          enable,
  output logic [1:0]    rate_sel,
  output logic          blink_mode,
  output logic [DW-1:0] level,
  output logic          restart
);
  logic [DW-1:0] ctrl_r, eff_r, level_r, rd_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_r  <= CTRL_RESET;
      eff_r   <= EFF_RESET;
      level_r <= '0;
      rd_r    <= '0;
    end else begin
      case (led_addr_e'(reg_addr))
        ADDR_CTRL:   rd_r <= ctrl_r;
        ADDR_EFFECT: rd_r <= eff_r;
        ADDR_LEVEL:  rd_r <= level_r;
        default:     rd_r <= '0;
      endcase
      if (wr_en) begin
        case (led_addr_e'(reg_addr))
          ADDR_CTRL:   ctrl_r  <= wr_data;
          ADDR_EFFECT: eff_r   <= wr_data;
          ADDR_LEVEL:  level_r <= wr_data;
          default:     ;
        endcase
      end
    end
  end

  always_comb begin
    restart = 1'b0;
    if (wr_en) begin
      if (led_addr_e'(reg_addr) == ADDR_CTRL)
        restart = wr_data[CTRL_RATE_LO +: 2] != ctrl_r[CTRL_RATE_LO +: 2];
      else if (led_addr_e'(reg_addr) == ADDR_EFFECT)
        restart = wr_data[EFF_BLINK_BIT] != eff_r[EFF_BLINK_BIT];
    end
  end

  assign rd_data    = rd_r;
  assign sw_own     = ctrl_r[CTRL_OWN_BIT];
  assign enable     = ctrl_r[CTRL_EN_BIT];
  assign rate_sel   = ctrl_r[CTRL_RATE_LO +: 2];
  assign blink_mode = eff_r[EFF_BLINK_BIT];
  assign level      = level_r;
endmodule

// File: rtl/led_timebase.sv
module led_timebase #(
  parameter int TICK_CLKS = 25_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic [1:0] rate_sel,
  output logic       blink_on
);
  localparam int PHASE_W = 4;
  localparam int PRE_W   = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;

  logic               tick;
  logic [PHASE_W-1:0] phase_r;

  generate
    if (TICK_CLKS > 1) begin : g_prescale
      logic [PRE_W-1:0] pre_r;
      assign tick = (pre_r == PRE_W'(TICK_CLKS - 1));
      always_ff @(posedge clk) begin
        if (rst || restart)  pre_r <= '0;
        else if (tick)       pre_r <= '0;
        else                 pre_r <= pre_r + 1'b1;
      end
    end else begin : g_noprescale
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || restart) phase_r <= '0;
    else if (tick)      phase_r <= phase_r + 1'b1;
  end

  // code 11 -> bit 0 (fastest), code 00 -> bit 3 (slowest)
  assign blink_on = ~phase_r[2'd3 - rate_sel];
endmodule

// File: rtl/led_pwm.sv
module led_pwm #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] level,
  output logic          pwm_on
);
  logic [DW-1:0] cnt_r;

  always_ff @(posedge clk) begin
    if (rst) cnt_r <= '0;
    else     cnt_r <= cnt_r + 1'b1;
  end

  assign pwm_on = cnt_r < level;
endmodule

// File: rtl/led_blink_pwm.sv
module led_blink_pwm
  import led_pkg::*;
#(
  parameter int TICK_CLKS = 25_000_000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          hw_status,
  output logic          led_out
);
  logic          sw_own, enable, blink_mode, restart, blink_on, pwm_on;
  logic [1:0]    rate_sel;
  logic [DW-1:0] level;
  logic          led_r, led_next;

  led_regs i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .sw_own(sw_own),
    .enable(enable), .rate_sel(rate_sel), .blink_mode(blink_mode),
    .level(level), .restart(restart)
  );

  led_timebase #(.TICK_CLKS(TICK_CLKS)) i_timebase (
    .clk(clk), .rst(rst), .restart(restart),
    .rate_sel(rate_sel), .blink_on(blink_on)
  );

  led_pwm #(.DW(DW)) i_pwm (
    .clk(clk), .rst(rst), .level(level), .pwm_on(pwm_on)
  );

  always_comb begin
    if (sw_own) led_next = enable && pwm_on && (!blink_mode || blink_on);
    else        led_next = hw_status;
  end

  always_ff @(posedge clk) begin
    if (rst) led_r <= 1'b0;
    else     led_r <= led_next;
  end

  assign led_out = led_r;
endmodule

// File: rtl/led_blink_pwm_chk.sv
module led_blink_pwm_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [1:0] reg_addr,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       hw_status,
  input logic       led_out,
  input logic       sw_own,
  input logic       enable,
  input logic [7:0] level,
  input logic       restart,
  input logic       blink_on
);
  AST_DISABLED_DARK: assert property (@(posedge clk) disable iff (rst)
    (sw_own && !enable) |=> !led_out); // R3

  AST_ZERO_LEVEL_DARK: assert property (@(posedge clk) disable iff (rst)
    (sw_own && level == 8'd0) |=> !led_out); // R4

  AST_HW_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !sw_own |=> (led_out == $past(hw_status))); // R8

  AST_RESTART_ON: assert property (@(posedge clk) disable iff (rst)
    restart |=> blink_on); // R9

  AST_LEVEL_READBACK: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_addr == 2'd2) ##1 (!wr_en && reg_addr == 2'd2)
      |=> (rd_data == $past(wr_data, 2))); // R2
endmodule

bind led_blink_pwm led_blink_pwm_chk i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .reg_addr(reg_addr),
  .wr_data(wr_data), .rd_data(rd_data), .hw_status(hw_status),
  .led_out(led_out), .sw_own(sw_own), .enable(enable), .level(level),
  .restart(restart), .blink_on(blink_on)
);

// File: tb/test_led_blink_pwm.sv
module test_led_blink_pwm;
  localparam int T = 4;

  logic       clk = 0, rst = 1, wr_en = 0, hw_status = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       led_out;

  int    n_run = 0, n_fail = 0;
  string cur_req = "R1";
  bit    finished = 0;

  always #5 clk = ~clk;

  led_blink_pwm #(.TICK_CLKS(T)) i_led_blink_pwm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .hw_status(hw_status),
    .led_out(led_out)
  );

  // behavioural reference model
  logic [7:0] m_ctrl, m_eff, m_lvl, exp_rd;
  int         m_pc, m_pos;
  bit         exp_led;

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 8'h08; m_eff = 8'h02; m_lvl = 0; m_pc = 0; m_pos = 0;
      exp_led = 0; exp_rd = 0;
    end else begin
      int  code, half;
      bit  on, rs;
      code = m_ctrl[5:4];
      half = T * (1 << (3 - code));
      on   = ((m_pos / half) % 2) == 0;
      if (m_ctrl[0]) exp_led = m_ctrl[1] && (m_pc < m_lvl) && (!m_eff[2] || on);
      else           exp_led = hw_status;
      case (reg_addr)
        2'd0: exp_rd = m_ctrl;
        2'd1: exp_rd = m_eff;
        2'd2: exp_rd = m_lvl;
        default: exp_rd = 0;
      endcase
      rs = 0;
      if (wr_en) begin
        case (reg_addr)
          2'd0: begin rs = wr_data[5:4] != m_ctrl[5:4]; m_ctrl = wr_data; end
          2'd1: begin rs = wr_data[2] != m_eff[2]; m_eff = wr_data; end
          2'd2: m_lvl = wr_data;
          default: ;
        endcase
      end
      m_pc  = (m_pc + 1) % 256;
      m_pos = rs ? 0 : (m_pos + 1) % (16 * T);
    end
  end

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle compare on every falling edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(cur_req, led_out, exp_led);
      check("R2", rd_data, exp_rd);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; reg_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input int exp, input string req);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    check(req, rd_data, exp);
  endtask

  task automatic duty_chk(input int exp, input string req);
    int hi = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (led_out) hi++;
    end
    check(req, hi, exp);
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    cur_req = "R1";
    check("R1", led_out, 0);
    rd_chk(2'd0, 8'h08, "R1");
    rd_chk(2'd1, 8'h02, "R1");
    rd_chk(2'd2, 8'h00, "R1");

    cur_req = "R2";
    wr(2'd0, 8'hC8); wr(2'd1, 8'h0A); wr(2'd2, 8'hA5); wr(2'd3, 8'h77);
    rd_chk(2'd0, 8'hC8, "R2");
    rd_chk(2'd1, 8'h0A, "R2");
    rd_chk(2'd2, 8'hA5, "R2");
    rd_chk(2'd3, 8'h00, "R2");

    cur_req = "R4";
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h0B);
    wr(2'd2, 8'd0);   duty_chk(0, "R4");
    wr(2'd2, 8'd1);   duty_chk(1, "R4");
    wr(2'd2, 8'd128); duty_chk(128, "R4");
    wr(2'd2, 8'd255); duty_chk(255, "R4");

    cur_req = "R3";
    wr(2'd0, 8'h09);  duty_chk(0, "R3");

    cur_req = "R6";
    wr(2'd0, 8'h0B);
    wr(2'd1, 8'h08);  duty_chk(255, "R6");
    wr(2'd1, 8'h00);  duty_chk(255, "R6");

    cur_req = "R7";
    wr(2'd1, 8'h04);
    for (int c = 3; c >= 0; c--) begin
      cur_req = (c == 0) ? "R5" : "R7";
      wr(2'd0, 8'h0B | 8'(c << 4));
      run(3 * 16 * T);
    end

    cur_req = "R9";
    wr(2'd0, 8'h3B); run(5);
    wr(2'd0, 8'h2B); run(3 * T);
    wr(2'd1, 8'h02); run(3);
    wr(2'd1, 8'h06); run(5 * T);

    cur_req = "R10";
    wr(2'd0, 8'h23); run(7);
    wr(2'd0, 8'hEF); run(40);

    cur_req = "R8";
    wr(2'd0, 8'h2A);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      hw_status = ((i * 7) % 5) < 2;
    end
    run(2);

    cur_req = "R11";
    hw_status = 0;
    wr(2'd0, 8'h0B); run(20);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule